// File: doc/BRIEF.md
# Rollout Work-Order Engine

The block takes generation work orders from a host, one per handshake, and queues them. A single worker takes the oldest queued order and counts one generated token per clock. It reports progress to the host as completion records, which wait in a second queue until the host pops them. Each order carries a trajectory tag, a starting sequence length, a token budget and a reward-model tag.

A long order is split at fixed token strides. At each stride boundary that lies below the budget, the worker posts a checkpoint record asking for a reward evaluation, then resumes counting. Malformed orders are answered with a single error record. Both queues apply backpressure. If the host stops popping, the completion queue fills and the worker parks on its pending record. Orders then pile up until the push side refuses new ones.

An optional level interrupt tells the host that records are waiting.

Top module: `rollout_ctl`

## Requirements
- R1: An order is taken only in a cycle with `push_valid_i` and `push_ready_o` both high. `push_ready_o` is low exactly while the order queue (DESC_DEPTH entries, default 4) is full. An order offered while `push_ready_o` is low is not taken and yields no record.
- R2: Orders are worked one at a time in acceptance order. The records of all orders reach the pop port in that same order, and no record is produced without an order.
- R3: An order with opcode 8'h01 and budget B≥1 ends with one record of status 8'h01 (done). That record carries length = start length + B, the order's trajectory tag and its reward-model tag.
- R4: For each multiple k·32 (k≥1) strictly below B, a record of status 8'h02 (reward checkpoint) with length = start + k·32 is emitted before the done record, in increasing k. Generation then resumes; for example, B=64 gives a checkpoint at start+32, then done at start+64.
- R5: An order whose opcode is not 8'h01, or whose budget is 0, produces exactly one record of status 8'hFF (error) with length = start length and echoed tags. It produces no checkpoint or done record.
- R6: While `pop_valid_o` is high and `pop_ready_i` is low, `pop_valid_o` stays high and all record fields stay unchanged. No record is ever lost.
- R7: When popping stops, the worker stalls once the completion queue (CMPL_DEPTH, default 4) is full, and `push_ready_o` eventually deasserts once the order queue fills.
- R8: `irq_o` is high exactly when `irq_en_i` is high and at least one record is waiting.
- R9: Asserting `rst_ni` low empties both queues and idles the worker. Immediately after, `push_ready_o`=1, `pop_valid_o`=0 and `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_en_i | input | 1 | Interrupt enable |
| push_valid_i | input | 1 | Order offered |
| push_ready_o | output | 1 | Order queue has room |
| push_op_i | input | 8 | Opcode, 8'h01 = generate |
| push_traj_i | input | 16 | Trajectory tag |
| push_start_i | input | 16 | Starting sequence length |
| push_budget_i | input | 16 | Token budget |
| push_rwd_i | input | 16 | Reward-model tag |
| pop_valid_o | output | 1 | Record waiting |
| pop_ready_i | input | 1 | Host takes the record |
| pop_traj_o | output | 16 | Trajectory tag of the record |
| pop_status_o | output | 8 | 8'h01 done, 8'h02 checkpoint, 8'hFF error |
| pop_len_o | output | 16 | Sequence length at the record |
| pop_rwd_o | output | 16 | Reward-model tag |
| irq_o | output | 1 | Records pending and interrupt enabled |

## Verification
The assertions assume the ring instances are only written or read through the top's gated handshakes. They also assume the host never changes nothing but its own inputs mid-cycle, so a held record has no source of change other than a pop.

The bench drives and samples only at the falling edge. It draws opcodes, budgets (including zero and values past several stride boundaries) and push/pop willingness from a fixed-seed `$urandom`. Orders are offered regardless of `push_ready_o`, which exercises refusal without ever breaking the handshake rules the assertions rely on.

// File: rtl/rollout_pkg.sv
package rollout_pkg;
  localparam logic [7:0] OP_GEN    = 8'h01;
  localparam logic [7:0] ST_DONE   = 8'h01;
  localparam logic [7:0] ST_REWARD = 8'h02;
  localparam logic [7:0] ST_ERR    = 8'hFF;

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] traj;
    logic [15:0] start;
    logic [15:0] budget;
    logic [15:0] rwd;
  } job_t;

  typedef struct packed {
    logic [15:0] traj;
    logic [7:0]  status;
    logic [15:0] len;
    logic [15:0] rwd;
  } cmpl_t;

  typedef enum logic [1:0] {W_IDLE, W_DECODE, W_COMPLETE} wstate_e;
endpackage

// File: rtl/ctl_ring.sv
module ctl_ring #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr_q, rd_ptr_q;

  assign empty_o   = (wr_ptr_q == rd_ptr_q);
  assign full_o    = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                     (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  assign rd_data_o = mem[rd_ptr_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en_i) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_ptr_q[AW-1:0]] <= wr_data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !empty_o); // R2
endmodule

// File: rtl/rollout_worker.sv
module rollout_worker
  import rollout_pkg::*;
#(
  parameter int STRIDE = 32
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  job_avail_i,
  input  job_t  job_i,
  output logic  job_take_o,
  output logic  cmpl_valid_o,
  output cmpl_t cmpl_o,
  input  logic  cmpl_ready_i
);
  localparam logic [15:0] STRIDE_W = 16'(STRIDE);

  wstate_e     state_q;
  job_t        job_q;
  logic [15:0] cnt_q, cnt_nxt;
  logic [7:0]  status_q;
  logic        job_bad;

  assign cnt_nxt      = cnt_q + 16'd1;
  assign job_bad      = (job_i.op != OP_GEN) || (job_i.budget == 16'd0);
  assign job_take_o   = (state_q == W_IDLE) && job_avail_i;
  assign cmpl_valid_o = (state_q == W_COMPLETE);

  always_comb begin
    cmpl_o.traj   = job_q.traj;
    cmpl_o.status = status_q;
    cmpl_o.len    = job_q.start + cnt_q;
    cmpl_o.rwd    = job_q.rwd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= W_IDLE;
      job_q    <= '0;
      cnt_q    <= '0;
      status_q <= '0;
    end else begin
      unique case (state_q)
        W_IDLE: if (job_avail_i) begin
          job_q <= job_i;
          cnt_q <= '0;
          if (job_bad) begin
            status_q <= ST_ERR;
            state_q  <= W_COMPLETE;
          end else begin
            state_q  <= W_DECODE;
          end
        end
        W_DECODE: begin
          cnt_q <= cnt_nxt;
          if (cnt_nxt >= job_q.budget) begin
            status_q <= ST_DONE;
            state_q  <= W_COMPLETE;
          end else if ((cnt_nxt % STRIDE_W) == 16'd0) begin
            status_q <= ST_REWARD;
            state_q  <= W_COMPLETE;
          end
        end
        W_COMPLETE: if (cmpl_ready_i) begin
          state_q <= (status_q == ST_REWARD) ? W_DECODE : W_IDLE;
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_o && !cmpl_ready_i |=> cmpl_valid_o && $stable(cmpl_o)); // R6
  AST_DECODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == W_DECODE |-> job_q.op == OP_GEN && job_q.budget != 16'd0); // R5
  AST_DONE_AT_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_o && status_q == ST_DONE |-> cnt_q == job_q.budget); // R3
  AST_REWARD_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_o && status_q == ST_REWARD |->
      cnt_q < job_q.budget && (cnt_q % STRIDE_W) == 16'd0); // R4
endmodule

// File: rtl/rollout_ctl.sv
module rollout_ctl
  import rollout_pkg::*;
#(
  parameter int DESC_DEPTH    = 4,
  parameter int CMPL_DEPTH    = 4,
  parameter int REWARD_STRIDE = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        irq_en_i,
  input  logic        push_valid_i,
  output logic        push_ready_o,
  input  logic [7:0]  push_op_i,
  input  logic [15:0] push_traj_i,
  input  logic [15:0] push_start_i,
  input  logic [15:0] push_budget_i,
  input  logic [15:0] push_rwd_i,
  output logic        pop_valid_o,
  input  logic        pop_ready_i,
  output logic [15:0] pop_traj_o,
  output logic [7:0]  pop_status_o,
  output logic [15:0] pop_len_o,
  output logic [15:0] pop_rwd_o,
  output logic        irq_o
);
  localparam int JOB_W  = $bits(job_t);
  localparam int CMPL_W = $bits(cmpl_t);

  job_t  push_job, head_job;
  cmpl_t wk_cmpl, head_cmpl;
  logic  desc_full, desc_empty, job_take;
  logic  cmpl_full, cmpl_empty, wk_valid, cmpl_wr;

  always_comb begin
    push_job.op     = push_op_i;
    push_job.traj   = push_traj_i;
    push_job.start  = push_start_i;
    push_job.budget = push_budget_i;
    push_job.rwd    = push_rwd_i;
  end

  assign push_ready_o = !desc_full;

  ctl_ring #(.WIDTH(JOB_W), .DEPTH(DESC_DEPTH)) i_desc_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (push_valid_i && push_ready_o),
    .wr_data_i (push_job),
    .rd_en_i   (job_take),
    .rd_data_o (head_job),
    .full_o    (desc_full),
    .empty_o   (desc_empty)
  );

  rollout_worker #(.STRIDE(REWARD_STRIDE)) i_worker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .job_avail_i  (!desc_empty),
    .job_i        (head_job),
    .job_take_o   (job_take),
    .cmpl_valid_o (wk_valid),
    .cmpl_o       (wk_cmpl),
    .cmpl_ready_i (!cmpl_full)
  );

  assign cmpl_wr = wk_valid && !cmpl_full;

  ctl_ring #(.WIDTH(CMPL_W), .DEPTH(CMPL_DEPTH)) i_cmpl_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cmpl_wr),
    .wr_data_i (wk_cmpl),
    .rd_en_i   (pop_valid_o && pop_ready_i),
    .rd_data_o (head_cmpl),
    .full_o    (cmpl_full),
    .empty_o   (cmpl_empty)
  );

  assign pop_valid_o  = !cmpl_empty;
  assign pop_traj_o   = head_cmpl.traj;
  assign pop_status_o = head_cmpl.status;
  assign pop_len_o    = head_cmpl.len;
  assign pop_rwd_o    = head_cmpl.rwd;
  assign irq_o        = irq_en_i && pop_valid_o;

  AST_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o && !pop_ready_i |=> pop_valid_o &&
      $stable({pop_traj_o, pop_status_o, pop_len_o, pop_rwd_o})); // R6
  AST_FULL_STALLS_WORKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wk_valid && cmpl_full && !pop_ready_i |=> wk_valid); // R7
endmodule

// File: tb/test_rollout_ctl.sv
`timescale 1ns/1ps
module test_rollout_ctl;
  localparam int WD_CYC = 150000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic irq_en_i = 1'b0;
  logic push_valid_i = 1'b0, pop_ready_i = 1'b0;
  logic [7:0]  push_op_i = '0;
  logic [15:0] push_traj_i = '0, push_start_i = '0, push_budget_i = '0, push_rwd_i = '0;
  logic        push_ready_o, pop_valid_o, irq_o;
  logic [15:0] pop_traj_o, pop_len_o, pop_rwd_o;
  logic [7:0]  pop_status_o;

  always #2.5 clk_i = ~clk_i;

  rollout_ctl i_rollout_ctl (
    .clk_i, .rst_ni, .irq_en_i, .push_valid_i, .push_ready_o,
    .push_op_i, .push_traj_i, .push_start_i, .push_budget_i, .push_rwd_i,
    .pop_valid_o, .pop_ready_i, .pop_traj_o, .pop_status_o, .pop_len_o,
    .pop_rwd_o, .irq_o
  );

  int n_tests = 0, n_fail = 0;
  logic [55:0] exp_q [$];
  logic [7:0]  nx_op;
  logic [15:0] nx_traj, nx_start, nx_budget, nx_rwd;
  logic        took;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected records for one accepted order (R3, R4, R5)
  function automatic void expand(input logic [7:0] op, input logic [15:0] traj,
                                 input logic [15:0] start, input logic [15:0] bud,
                                 input logic [15:0] rwd);
    if (op != 8'h01 || bud == 16'd0) begin
      exp_q.push_back({traj, 8'hFF, start, rwd});
    end else begin
      for (int m = 32; m < int'(bud); m += 32)
        exp_q.push_back({traj, 8'h02, 16'(int'(start) + m), rwd});
      exp_q.push_back({traj, 8'h01, 16'(start + bud), rwd});
    end
  endfunction

  task automatic check_pop();
    logic [55:0] act, e;
    string req;
    act = {pop_traj_o, pop_status_o, pop_len_o, pop_rwd_o};
    if (exp_q.size() == 0) begin
      chk(1'b0, "R2 unexpected record", 64'(act), 64'd0);
    end else begin
      e = exp_q.pop_front();
      req = (e[39:32] == 8'h01) ? "R3 done" : (e[39:32] == 8'h02) ? "R4 checkpoint" : "R5 error";
      chk(act == e, req, 64'(act), 64'(e));
    end
  endtask

  // drive and sample at falling edge; handshakes complete at the next rising edge
  task automatic step(input bit pv, input bit pr);
    @(negedge clk_i);
    push_valid_i = pv; pop_ready_i = pr;
    push_op_i = nx_op; push_traj_i = nx_traj; push_start_i = nx_start;
    push_budget_i = nx_budget; push_rwd_i = nx_rwd;
    took = pv && push_ready_o;
    if (took) expand(nx_op, nx_traj, nx_start, nx_budget, nx_rwd);
    if (pr && pop_valid_o) check_pop();
  endtask

  task automatic set_desc(input logic [7:0] op, input logic [15:0] traj,
                          input logic [15:0] start, input logic [15:0] bud,
                          input logic [15:0] rwd);
    nx_op = op; nx_traj = traj; nx_start = start; nx_budget = bud; nx_rwd = rwd;
  endtask

  task automatic push_one(input logic [7:0] op, input logic [15:0] traj,
                          input logic [15:0] start, input logic [15:0] bud,
                          input logic [15:0] rwd);
    set_desc(op, traj, start, bud, rwd);
    for (int i = 0; i < 200; i++) begin
      step(1'b1, 1'b1);
      if (took) break;
    end
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 20000 && exp_q.size() != 0; i++) step(1'b0, 1'b1);
    chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    repeat (8) step(1'b0, 1'b1);
    chk(pop_valid_o == 1'b0, "R2 no extra record", 64'(pop_valid_o), 64'd0);
  endtask

  task automatic rand_desc();
    int r;
    r = int'($urandom % 10);
    nx_op     = ($urandom % 8 == 0) ? 8'($urandom) : 8'h01;
    nx_budget = (r == 0) ? 16'd0 : (r < 7) ? 16'(1 + $urandom % 20) : 16'(1 + $urandom % 110);
    nx_traj   = 16'($urandom);
    nx_start  = 16'($urandom % 1000);
    nx_rwd    = 16'($urandom);
  endtask

  initial begin
    #(WD_CYC * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [55:0] snap;
    void'($urandom(32'd4711));
    set_desc(8'h01, 16'd0, 16'd0, 16'd1, 16'd0);
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(push_ready_o == 1'b1, "R9 push_ready", 64'(push_ready_o), 64'd1);
    chk(pop_valid_o == 1'b0, "R9 pop_valid", 64'(pop_valid_o), 64'd0);
    chk(irq_o == 1'b0, "R9 irq", 64'(irq_o), 64'd0);
    rst_ni = 1'b1;

    // R3 plain run, R4 stride splits, R5 bad orders
    push_one(8'h01, 16'd7, 16'd0, 16'd10, 16'd1);
    push_one(8'h01, 16'd8, 16'd5, 16'd64, 16'd2);
    push_one(8'h01, 16'd9, 16'd0, 16'd32, 16'd3);
    push_one(8'h01, 16'd10, 16'd100, 16'd97, 16'd4);
    push_one(8'h03, 16'd11, 16'd20, 16'd50, 16'd5);
    push_one(8'h01, 16'd12, 16'd30, 16'd0, 16'd6);
    drain("R2 all directed records seen");

    // R7 sustained stall, R6 hold, R8 interrupt
    irq_en_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      set_desc(8'h01, 16'(100 + i), 16'(i), 16'd3, 16'd9);
      step(1'b1, 1'b0);
    end
    step(1'b0, 1'b0);
    chk(push_ready_o == 1'b0, "R7 push_ready deasserted", 64'(push_ready_o), 64'd0);
    chk(irq_o == 1'b1, "R8 irq with enable", 64'(irq_o), 64'd1);
    chk(pop_valid_o == 1'b1, "R6 record pending", 64'(pop_valid_o), 64'd1);
    snap = {pop_traj_o, pop_status_o, pop_len_o, pop_rwd_o};
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b0);
      chk(pop_valid_o && snap == {pop_traj_o, pop_status_o, pop_len_o, pop_rwd_o},
          "R6 record held", 64'({pop_traj_o, pop_status_o, pop_len_o, pop_rwd_o}), 64'(snap));
    end
    irq_en_i = 1'b0; #1;
    chk(irq_o == 1'b0, "R8 irq masked", 64'(irq_o), 64'd0);
    drain("R6 no record lost after stall");
    irq_en_i = 1'b1; #1;
    chk(irq_o == 1'b0, "R8 irq quiet when empty", 64'(irq_o), 64'd0);
    irq_en_i = 1'b0;

    // randomized mix, R1 refusals included
    for (int i = 0; i < 6000; i++) begin
      rand_desc();
      step(($urandom % 3) != 0, ($urandom % 4) != 0);
    end
    drain("R1 R2 random orders all answered");

    // R9 reset with work in flight
    for (int i = 0; i < 12; i++) begin
      set_desc(8'h01, 16'(200 + i), 16'd0, 16'd40, 16'd1);
      step(1'b1, 1'b0);
    end
    @(negedge clk_i);
    push_valid_i = 1'b0; rst_ni = 1'b0; irq_en_i = 1'b1; #1;
    chk(push_ready_o == 1'b1, "R9 push_ready after reset", 64'(push_ready_o), 64'd1);
    chk(pop_valid_o == 1'b0, "R9 pop_valid after reset", 64'(pop_valid_o), 64'd0);
    chk(irq_o == 1'b0, "R9 irq after reset", 64'(irq_o), 64'd0);
    exp_q.delete();
    @(negedge clk_i);
    rst_ni = 1'b1; irq_en_i = 1'b0;
    push_one(8'h01, 16'd77, 16'd1, 16'd33, 16'd2);
    drain("R9 clean restart");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule